// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block holds one port-membership mask for every VLAN ID. The host configures it through a small 32-bit register bus with two words. The index word selects a VLAN ID, and the entry number is the VID itself. The control word carries a two-bit command and status field and a seven-bit port mask.

To issue a command, the host writes the control word. A write command stores the mask into the selected entry. A read command copies the selected entry back into the mask field. A clear command zeroes the whole table, one entry per clock. The command field reads back nonzero while the engine works and returns to zero once the operation is done.

Forwarding logic uses a separate lookup port. It presents a VID and receives that VLAN's member mask on the next clock. While a clear sweep runs, the lookup port answers with an empty mask, so the forwarding logic never sees a half-cleared table.

Top module: `vlan_table_engine`

## Requirements
- R1: After reset, the control word and the index word both read 0 and the lookup mask output is 0.
- R2: The bus has two words. Address 0 is the control word: bits [1:0] hold the command/status code (0 idle, 1 read, 2 write, 3 clear), bits [8:2] hold the port mask and all higher bits read 0. Address 1 is the index word: bits [11:0] hold the VID and all higher bits read 0.
- R3: A write command (code 2) stores the mask field into the entry selected by the index word. The status reads 2 for one cycle and then reads 0.
- R4: A read command (code 1) loads the selected entry into mask bits [8:2]. The status reads 1 for one cycle and then reads 0.
- R5: A clear command (code 3) zeroes every entry, one entry per clock. The status reads 3 for exactly 4096 cycles and then reads 0.
- R6: While the status is nonzero, bus writes to the control word and to the index word are ignored.
- R7: The lookup output shows the mask of the entry for the VID presented on the previous clock.
- R8: The lookup output is 0 on every cycle after a clock edge where a clear sweep was in progress.
- R9: Writing an all-zero mask to an entry removes every port from that VLAN, so a lookup of it returns 0.
- R10: A control-word write with code 0 only updates the mask field and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 control, 1 index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| lk_vid | input | 12 | VID to look up |
| lk_mask | output | 7 | Member mask of the VID presented on the previous cycle |

## Verification
A stuck or wrongly advanced sweep counter shows up in the status field. The status either leaves 3 before cycle 4096 or stays at 3 after it, so the bench counts the exact cycle of the transition. A wrong write address or wrong write data corrupts the table. That corruption appears on the next lookup or read command of the affected VID, so random traffic is compared against a bench model and small VID ranges are reused to make collisions likely. A busy flag that leaks commands shows up within one cycle, as a status or mask field that changes during a sweep.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
  localparam int CMD_W = 2;

  typedef enum logic [CMD_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_CLEAR = 2'd3
  } vlt_cmd_e;

  localparam logic REG_CTRL  = 1'b0;
  localparam logic REG_INDEX = 1'b1;
endpackage

// File: rtl/vlt_store.sv
module vlt_store #(
  parameter int VID_W = 12,
  parameter int PORTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VID_W-1:0] waddr,
  input  logic [PORTS-1:0] wdata,
  input  logic [VID_W-1:0] host_raddr,
  output logic [PORTS-1:0] host_rdata,
  input  logic             blank,
  input  logic [VID_W-1:0] lk_vid,
  output logic [PORTS-1:0] lk_mask
);
  localparam int DEPTH = 1 << VID_W;

  logic [PORTS-1:0] tbl [DEPTH];
  logic [PORTS-1:0] lk_q, lk_d;

  always_ff @(posedge clk) begin
    if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  assign host_rdata = tbl[host_raddr];

  always_comb begin
    lk_d = blank ? '0 : tbl[lk_vid];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= '0;
    end else begin
      lk_q <= lk_d;
    end
  end

  assign lk_mask = lk_q;

  p_blank_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (lk_mask == '0));

  p_entry_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tbl[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/vlt_ctrl.sv
module vlt_ctrl
  import vlt_pkg::*;
#(
  parameter int VID_W = 12,
  parameter int PORTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [PORTS-1:0] ent_rdata,
  output logic [VID_W-1:0] ent_raddr,
  output logic             mem_we,
  output logic [VID_W-1:0] mem_waddr,
  output logic [PORTS-1:0] mem_wdata,
  output logic             sweeping
);
  localparam int MASK_LO = CMD_W;
  localparam int MASK_HI = CMD_W + PORTS - 1;
  localparam logic [VID_W-1:0] LAST = '1;

  vlt_cmd_e         st_q, st_d;
  logic [PORTS-1:0] mask_q, mask_d;
  logic [VID_W-1:0] idx_q, idx_d;
  logic [VID_W-1:0] cnt_q, cnt_d;
  logic             ctrl_wr, idx_wr;

  assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
  assign idx_wr  = bus_wr && (bus_addr == REG_INDEX);

  always_comb begin
    st_d      = st_q;
    mask_d    = mask_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    mem_we    = 1'b0;
    mem_waddr = idx_q;
    mem_wdata = mask_q;
    case (st_q)
      ST_IDLE: begin
        if (ctrl_wr) begin
          st_d   = vlt_cmd_e'(bus_wdata[CMD_W-1:0]);
          mask_d = bus_wdata[MASK_HI:MASK_LO];
          cnt_d  = '0;
        end
        if (idx_wr) begin
          idx_d = bus_wdata[VID_W-1:0];
        end
      end
      ST_READ: begin
        mask_d = ent_rdata;
        st_d   = ST_IDLE;
      end
      ST_WRITE: begin
        mem_we = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_CLEAR: begin
        mem_we    = 1'b1;
        mem_waddr = cnt_q;
        mem_wdata = '0;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ent_raddr = idx_q;
  assign sweeping  = (st_q == ST_CLEAR);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_CTRL) begin
      bus_rdata[CMD_W-1:0]      = st_q;
      bus_rdata[MASK_HI:MASK_LO] = mask_q;
    end else begin
      bus_rdata[VID_W-1:0] = idx_q;
    end
  end

  p_write_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRITE) |=> (st_q == ST_IDLE));

  p_read_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ) |=> (st_q == ST_IDLE));

  p_sweep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLEAR && cnt_q != LAST) |=> (st_q == ST_CLEAR));

  p_sweep_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLEAR && cnt_q == LAST) |=> (st_q == ST_IDLE));

  p_busy_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(idx_q));

  p_busy_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLEAR || st_q == ST_WRITE) |=> $stable(mask_q));
endmodule

// File: rtl/vlan_table_engine.sv
module vlan_table_engine #(
  parameter int VID_W = 12,
  parameter int PORTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [VID_W-1:0] lk_vid,
  output logic [PORTS-1:0] lk_mask
);
  logic [PORTS-1:0] ent_rdata;
  logic [VID_W-1:0] ent_raddr;
  logic             mem_we;
  logic [VID_W-1:0] mem_waddr;
  logic [PORTS-1:0] mem_wdata;
  logic             sweeping;

  vlt_ctrl #(.VID_W(VID_W), .PORTS(PORTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ent_rdata (ent_rdata),
    .ent_raddr (ent_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .sweeping  (sweeping)
  );

  vlt_store #(.VID_W(VID_W), .PORTS(PORTS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (mem_we),
    .waddr      (mem_waddr),
    .wdata      (mem_wdata),
    .host_raddr (ent_raddr),
    .host_rdata (ent_rdata),
    .blank      (sweeping),
    .lk_vid     (lk_vid),
    .lk_mask    (lk_mask)
  );
endmodule

// File: tb/sim_vlan_table_engine.sv
module sim_vlan_table_engine;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [11:0] lk_vid;
  logic [6:0]  lk_mask;

  int n_checks = 0;
  int n_fail   = 0;
  bit [6:0] model [4096];

  vlan_table_engine u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lk_vid    (lk_vid),
    .lk_mask   (lk_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [1:0] cmd, input logic [6:0] m);
    return {23'd0, m, cmd};
  endfunction

  task automatic bus_write(input logic a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic read_word(input logic a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_write(input logic [11:0] vid, input logic [6:0] m);
    logic [31:0] r;
    bus_write(1'b1, {20'd0, vid});
    bus_write(1'b0, ctrl_word(2'd2, m));
    read_word(1'b0, r);
    check("R3 write status busy", r[1:0], 32'd2);
    @(negedge clk);
    read_word(1'b0, r);
    check("R3 write status idle", r[1:0], 32'd0);
    model[vid] = m;
  endtask

  task automatic do_read(input logic [11:0] vid);
    logic [31:0] r;
    bus_write(1'b1, {20'd0, vid});
    bus_write(1'b0, ctrl_word(2'd1, 7'd0));
    @(negedge clk);
    read_word(1'b0, r);
    check("R4 read result", r, ctrl_word(2'd0, model[vid]));
  endtask

  task automatic do_lookup(input logic [11:0] vid, input string req);
    lk_vid = vid;
    @(negedge clk);
    check(req, {25'd0, lk_mask}, {25'd0, model[vid]});
  endtask

  task automatic do_clear(input bit check_blank);
    logic [31:0] r;
    bus_write(1'b0, ctrl_word(2'd3, 7'd0));
    for (int k = 1; k < 4096; k++) begin
      if (k == 7 && check_blank) begin
        bus_write(1'b0, ctrl_word(2'd2, 7'h55));
        read_word(1'b0, r);
        check("R6 ctrl ignored while busy", r, ctrl_word(2'd3, 7'd0));
        bus_write(1'b1, 32'd99);
        read_word(1'b1, r);
        check("R6 index ignored while busy", r, 32'd5);
        k = k + 1;
      end else begin
        @(negedge clk);
      end
      if (k == 100 && check_blank) begin
        check("R8 lookup zero in sweep", {25'd0, lk_mask}, 32'd0);
      end
    end
    read_word(1'b0, r);
    check("R5 still clearing at 4095", r[1:0], 32'd3);
    @(negedge clk);
    read_word(1'b0, r);
    check("R5 idle after 4096", r[1:0], 32'd0);
    for (int v = 0; v < 4096; v++) model[v] = 7'd0;
  endtask

  initial begin
    logic [31:0] r;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    bus_addr = 1'b0;
    bus_wdata = '0;
    lk_vid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(1'b0, r);
    check("R1 ctrl after reset", r, 32'd0);
    read_word(1'b1, r);
    check("R1 index after reset", r, 32'd0);
    check("R1 lookup after reset", {25'd0, lk_mask}, 32'd0);

    bus_write(1'b1, 32'hFFFF_FABC);
    read_word(1'b1, r);
    check("R2 index field width", r, 32'h0000_0ABC);
    bus_write(1'b0, 32'hFFFF_FE00 | ctrl_word(2'd0, 7'h2A));
    read_word(1'b0, r);
    check("R2 ctrl field layout", r, ctrl_word(2'd0, 7'h2A));

    do_clear(1'b0);
    do_lookup(12'hABC, "R5 entry cleared");

    do_write(12'd0, 7'h7F);
    do_write(12'd4095, 7'h41);
    do_lookup(12'd0, "R7 lookup vid 0");
    do_lookup(12'd4095, "R7 lookup vid 4095");
    do_read(12'd4095);

    bus_write(1'b1, 32'd0);
    bus_write(1'b0, ctrl_word(2'd0, 7'h13));
    @(negedge clk);
    do_lookup(12'd0, "R10 idle code leaves table");
    do_read(12'd0);

    do_write(12'd0, 7'd0);
    do_lookup(12'd0, "R9 zero mask removes ports");

    for (int i = 0; i < 300; i++) begin
      logic [11:0] v;
      int op;
      v  = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 16);
      op = $urandom % 3;
      if (op == 0) do_write(v, 7'($urandom));
      else if (op == 1) do_read(v);
      else do_lookup(v, "R7 random lookup");
    end

    do_write(12'd200, 7'h3C);
    do_write(12'd5, 7'h11);
    lk_vid = 12'd200;
    do_clear(1'b1);
    do_lookup(12'd200, "R5 entry zero after second clear");
    do_read(12'd5);
    summary();
  end
endmodule